// File: doc/BRIEF.md
# Vectored Exception Entry Unit

This block is the exception front end of a small processor core. The core gives it the PC of the instruction in flight, two synchronous trap flags and an asynchronous interrupt request. When the unit takes an exception, it records a cause code and saves the faulting PC. It then moves the core into kernel mode with interrupts masked and steers the next fetch to a handler address computed from the cause. Each cause gets a 32-instruction slot: the address is a base plus the cause shifted left by seven.

A return request undoes the entry in one step. The unit gives the saved PC as the next fetch address and restores the mode and interrupt-enable bits that were in force before the last entry. A one-deep stack holds those bits. The unit never writes the general link register, so a handler can be entered from any point without losing it.

After reset the one-deep stack holds user mode with interrupts enabled. Boot code can therefore drop into user level with a single return.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset `kernel_o`=1, `int_en_o`=0, `cause_o`=0 and `epc_o`=0.
- R2: An undefined-instruction trap raises `entry_o` and `redirect_o` in the same cycle, with `next_pc_o`=0x80. From the next cycle `cause_o`=0 and `epc_o` equals the `pc_i` of the trap cycle.
- R3: An arithmetic-overflow trap is taken with cause code 1 and `next_pc_o`=0x100.
- R4: An interrupt request is taken only while `int_en_o`=1, with cause code 2 and `next_pc_o`=0x180. While `int_en_o`=0 a lone request raises no entry and changes no visible state.
- R5: Simultaneous causes are ranked undefined instruction, then overflow, then interrupt. Only the winner's code and vector are used.
- R6: From the cycle after any entry, `kernel_o`=1 and `int_en_o`=0.
- R7: A return request without an entry raises `redirect_o` with `next_pc_o` equal to `epc_o` in the same cycle. From the next cycle the mode and enable bits saved by the last entry are in force.
- R8: An entry in the same cycle as a return request takes precedence, and the return is dropped.
- R9: With no entry since reset, a return yields user mode (`kernel_o`=0) with `int_en_o`=1.
- R10: While `redirect_o` is low, `entry_o` is low and `next_pc_o` is 0.
- R11: An entry taken in kernel mode overwrites the cause and exception PC. The following return restores kernel mode with interrupts masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | PC of the current instruction |
| trap_undef_i | input | 1 | Undefined instruction detected |
| trap_ovf_i | input | 1 | Arithmetic overflow detected |
| irq_i | input | 1 | Asynchronous interrupt request |
| eret_i | input | 1 | Return-from-exception request |
| redirect_o | output | 1 | Next PC override valid this cycle |
| next_pc_o | output | XLEN | Override fetch address |
| entry_o | output | 1 | Exception accepted this cycle |
| cause_o | output | CAUSE_W | Recorded cause code |
| epc_o | output | XLEN | Saved exception PC |
| kernel_o | output | 1 | Kernel mode active |
| int_en_o | output | 1 | Interrupts enabled |

## Verification
`entry_o`, `redirect_o` and `next_pc_o` are combinational and are due in the cycle the stimulus is applied. The bench drives each vector after a falling edge and samples these outputs a little later, before the next rising edge. `cause_o`, `epc_o`, `kernel_o` and `int_en_o` pass through one register and are due one cycle later. The bench samples them just after the rising edge that closes the stimulus cycle. It applies the next vector only after that sample, so every check sees the effect of exactly one vector.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int CAUSE_W = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_UNDEF = 2'd0,
        CAUSE_OVF   = 2'd1,
        CAUSE_IRQ   = 2'd2
    } cause_e;

    typedef struct packed {
        logic kernel;
        logic ie;
    } mode_t;

    localparam mode_t MODE_HANDLER = '{kernel: 1'b1, ie: 1'b0};
    localparam mode_t MODE_BOOT_RET = '{kernel: 1'b0, ie: 1'b1};
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   undef_i,
    input  logic   ovf_i,
    input  logic   irq_i,
    input  logic   ie_i,
    output logic   take_o,
    output cause_e cause_o
);
    logic irq_ok;

    always_comb begin
        irq_ok  = irq_i & ie_i;
        take_o  = undef_i | ovf_i | irq_ok;
        if (undef_i)    cause_o = CAUSE_UNDEF;
        else if (ovf_i) cause_o = CAUSE_OVF;
        else            cause_o = CAUSE_IRQ;
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int unsigned VEC_BASE   = 32'h80,
    parameter int          SLOT_SHIFT = 7,
    parameter bit          VECTORED   = 1'b1
) (
    input  cause_e            cause_i,
    output logic [XLEN-1:0]   vec_o
);
    localparam logic [XLEN-1:0] BASE = XLEN'(VEC_BASE);

    generate
        if (VECTORED) begin : g_vectored
            logic [XLEN-1:0] wide_cause;
            always_comb begin
                wide_cause = {{(XLEN-CAUSE_W){1'b0}}, cause_i};
                vec_o      = BASE + (wide_cause << SLOT_SHIFT);
            end
        end else begin : g_single
            logic unused_cause;
            always_comb begin
                unused_cause = ^cause_i;
                vec_o        = BASE;
            end
        end
    endgenerate
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int unsigned VEC_BASE   = 32'h80,
    parameter int          SLOT_SHIFT = 7,
    parameter bit          VECTORED   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               trap_undef_i,
    input  logic               trap_ovf_i,
    input  logic               irq_i,
    input  logic               eret_i,
    output logic               redirect_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic               entry_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0]    epc_o,
    output logic               kernel_o,
    output logic               int_en_o
);
    typedef struct packed {
        cause_e          cause;
        logic [XLEN-1:0] epc;
        mode_t           cur;
        mode_t           saved;
    } state_t;

    state_t          st_d, st_q;
    logic            take;
    cause_e          win_cause;
    logic [XLEN-1:0] vec;
    logic            redir_d;
    logic [XLEN-1:0] npc_d;

    exc_arbiter u_arb (
        .undef_i (trap_undef_i),
        .ovf_i   (trap_ovf_i),
        .irq_i   (irq_i),
        .ie_i    (st_q.cur.ie),
        .take_o  (take),
        .cause_o (win_cause)
    );

    exc_vector_gen #(
        .XLEN       (XLEN),
        .VEC_BASE   (VEC_BASE),
        .SLOT_SHIFT (SLOT_SHIFT),
        .VECTORED   (VECTORED)
    ) u_vec (
        .cause_i (win_cause),
        .vec_o   (vec)
    );

    // Next-state and redirect computation
    always_comb begin
        st_d    = st_q;
        redir_d = 1'b0;
        npc_d   = '0;
        if (take) begin
            st_d.cause = win_cause;
            st_d.epc   = pc_i;
            st_d.saved = st_q.cur;
            st_d.cur   = MODE_HANDLER;
            redir_d    = 1'b1;
            npc_d      = vec;
        end else if (eret_i) begin
            st_d.cur = st_q.saved;
            redir_d  = 1'b1;
            npc_d    = st_q.epc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cause <= CAUSE_UNDEF;
            st_q.epc   <= '0;
            st_q.cur   <= MODE_HANDLER;
            st_q.saved <= MODE_BOOT_RET;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o = redir_d;
    assign next_pc_o  = npc_d;
    assign entry_o    = take;
    assign cause_o    = st_q.cause;
    assign epc_o      = st_q.epc;
    assign kernel_o   = st_q.cur.kernel;
    assign int_en_o   = st_q.cur.ie;
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [XLEN-1:0]    pc_i,
    input logic               trap_undef_i,
    input logic               trap_ovf_i,
    input logic               irq_i,
    input logic               eret_i,
    input logic               redirect_o,
    input logic [XLEN-1:0]    next_pc_o,
    input logic               entry_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [XLEN-1:0]    epc_o,
    input logic               kernel_o,
    input logic               int_en_o
);
    // R2
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> epc_o == $past(pc_i));

    // R2
    undef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_undef_i |=> cause_o == CAUSE_W'(0));

    // R4
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !int_en_o && !trap_undef_i && !trap_ovf_i) |-> !entry_o);

    // R5
    ovf_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ovf_i && !trap_undef_i) |=> cause_o == CAUSE_W'(1));

    // R6
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> (kernel_o && !int_en_o));

    // R7
    eret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !entry_o) |-> (redirect_o && next_pc_o == epc_o));

    // R7
    eret_keeps_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !entry_o) |=> $stable(epc_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> (!entry_o && next_pc_o == '0));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.XLEN(XLEN)) u_exc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_i         (pc_i),
    .trap_undef_i (trap_undef_i),
    .trap_ovf_i   (trap_ovf_i),
    .irq_i        (irq_i),
    .eret_i       (eret_i),
    .redirect_o   (redirect_o),
    .next_pc_o    (next_pc_o),
    .entry_o      (entry_o),
    .cause_o      (cause_o),
    .epc_o        (epc_o),
    .kernel_o     (kernel_o),
    .int_en_o     (int_en_o)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
    localparam int XLEN = 32;
    localparam int NV   = 15;
    localparam int VW   = 106;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] pc_i;
    logic            trap_undef_i, trap_ovf_i, irq_i, eret_i;
    logic            redirect_o, entry_o, kernel_o, int_en_o;
    logic [XLEN-1:0] next_pc_o, epc_o;
    logic [1:0]      cause_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
        .trap_undef_i(trap_undef_i), .trap_ovf_i(trap_ovf_i),
        .irq_i(irq_i), .eret_i(eret_i),
        .redirect_o(redirect_o), .next_pc_o(next_pc_o), .entry_o(entry_o),
        .cause_o(cause_o), .epc_o(epc_o), .kernel_o(kernel_o), .int_en_o(int_en_o)
    );

    // stim{undef,ovf,irq,eret}, pc, entry, redirect, next_pc, cause, epc, kernel, ie
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'b0010, 32'h1000, 1'b0, 1'b0, 32'h0,    2'd0, 32'h0,    1'b1, 1'b0}, // R4 masked
        {4'b0000, 32'h1004, 1'b0, 1'b0, 32'h0,    2'd0, 32'h0,    1'b1, 1'b0}, // R10 idle
        {4'b0001, 32'h1008, 1'b0, 1'b1, 32'h0,    2'd0, 32'h0,    1'b0, 1'b1}, // R9 boot return
        {4'b1000, 32'h2000, 1'b1, 1'b1, 32'h80,   2'd0, 32'h2000, 1'b1, 1'b0}, // R2 undef
        {4'b0001, 32'h0084, 1'b0, 1'b1, 32'h2000, 2'd0, 32'h2000, 1'b0, 1'b1}, // R7 return
        {4'b0100, 32'h3000, 1'b1, 1'b1, 32'h100,  2'd1, 32'h3000, 1'b1, 1'b0}, // R3 overflow
        {4'b0001, 32'h0104, 1'b0, 1'b1, 32'h3000, 2'd1, 32'h3000, 1'b0, 1'b1}, // R7
        {4'b0010, 32'h4000, 1'b1, 1'b1, 32'h180,  2'd2, 32'h4000, 1'b1, 1'b0}, // R4 taken
        {4'b0001, 32'h0184, 1'b0, 1'b1, 32'h4000, 2'd2, 32'h4000, 1'b0, 1'b1}, // R6 R7
        {4'b1110, 32'h5000, 1'b1, 1'b1, 32'h80,   2'd0, 32'h5000, 1'b1, 1'b0}, // R5 all
        {4'b0100, 32'h0084, 1'b1, 1'b1, 32'h100,  2'd1, 32'h0084, 1'b1, 1'b0}, // R11 nested
        {4'b0001, 32'h0104, 1'b0, 1'b1, 32'h0084, 2'd1, 32'h0084, 1'b1, 1'b0}, // R11 back to kernel
        {4'b0010, 32'h0088, 1'b0, 1'b0, 32'h0,    2'd1, 32'h0084, 1'b1, 1'b0}, // R4 masked
        {4'b0101, 32'h008c, 1'b1, 1'b1, 32'h100,  2'd1, 32'h008c, 1'b1, 1'b0}, // R8
        {4'b0110, 32'h0090, 1'b1, 1'b1, 32'h100,  2'd1, 32'h0090, 1'b1, 1'b0}  // R5 ovf over irq
    };
    localparam int REQ [NV] = '{4, 10, 9, 2, 7, 3, 7, 4, 6, 5, 11, 11, 4, 8, 5};

    task automatic chk(input int req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic [XLEN-1:0] pc);
        {trap_undef_i, trap_ovf_i, irq_i, eret_i} = s;
        pc_i = pc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(4'b0000, '0);
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(1, "kernel", XLEN'(kernel_o), 1);
        chk(1, "int_en", XLEN'(int_en_o), 0);
        chk(1, "cause",  XLEN'(cause_o),  0);
        chk(1, "epc",    epc_o,           0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][105:102], VEC[i][101:70]);
            #2;
            chk(REQ[i], "entry",    XLEN'(entry_o),    XLEN'(VEC[i][69]));
            chk(REQ[i], "redirect", XLEN'(redirect_o), XLEN'(VEC[i][68]));
            chk(REQ[i], "next_pc",  next_pc_o,         VEC[i][67:36]);
            @(posedge clk);
            #2;
            chk(REQ[i], "cause",  XLEN'(cause_o),  XLEN'(VEC[i][35:34]));
            chk(REQ[i], "epc",    epc_o,           VEC[i][33:2]);
            chk(REQ[i], "kernel", XLEN'(kernel_o), XLEN'(VEC[i][1]));
            chk(REQ[i], "int_en", XLEN'(int_en_o), XLEN'(VEC[i][0]));
        end

        // R1 reset during operation clears the state again
        @(negedge clk);
        drive(4'b0000, '0);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk(1, "kernel after rerun reset", XLEN'(kernel_o), 1);
        chk(1, "epc after rerun reset",    epc_o,           0);
        chk(1, "cause after rerun reset",  XLEN'(cause_o),  0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 boot return, then R8 interrupt beating a return
        drive(4'b0001, 32'h10);
        @(posedge clk);
        #2;
        chk(9, "kernel after boot return", XLEN'(kernel_o), 0);
        chk(9, "int_en after boot return", XLEN'(int_en_o), 1);
        @(negedge clk);
        drive(4'b0011, 32'h6000);
        #2;
        chk(8, "entry irq+eret",   XLEN'(entry_o), 1);
        chk(8, "next_pc irq+eret", next_pc_o,      32'h180);
        @(posedge clk);
        #2;
        chk(8, "cause irq+eret", XLEN'(cause_o), 2);
        chk(8, "epc irq+eret",   epc_o,          32'h6000);
        @(negedge clk);
        drive(4'b0000, '0);
        #2;
        chk(10, "idle next_pc", next_pc_o,         0);
        chk(10, "idle redirect", XLEN'(redirect_o), 0);

        finish_run();
    end
endmodule